// File: doc/BRIEF.md
# Per-Core Interrupt Enable and Acceptance Gate

This block keeps the enable state and the six local source entries of a per-core interrupt controller, and decides for each incoming typed interrupt request whether the core takes it. Software reaches the state through a simple word-wide register port. The port is addressed by byte offset. Writes take effect on the clock edge and reads are combinational. The block has a hardware enable input and a software enable bit. The software enable bit is held in the spurious-vector register.

Each request carries a kind code. The block answers in the same cycle with an accept or reject pulse. It also drives a hold flag, which tells the neighbouring request/in-service logic to freeze its pending bits. It drives one effective mask bit per local source, which the local interrupt sources use to decide whether they may fire. Clearing the software enable keeps the system-class requests (SMI, NMI, INIT, startup, remote read, local pin) flowing. It refuses the ordinary vectored ones and pins every source mask at masked.

Top module: `irq_accept_gate`

## Requirements
- R1: After reset every source entry reads 00010000h, the spurious-vector register reads 000000FFh, all `lvt_mask` bits are 1 and `hold_pending` is 1.
- R2: Source entries sit at offsets 320h, 330h, 340h, 350h, 360h and 370h (timer, thermal, performance, pin 0, pin 1, error), and entry i drives `lvt_mask[i]`. Each entry keeps the vector in bits 7:0, the message type in bits 10:8, the trigger mode in bit 15 and the mask in bit 16. All other bits read 0.
- R3: The spurious-vector register at offset F0h keeps bits 8:0, and bit 8 is the software enable. Its other bits read 0, and it changes only on a write to F0h.
- R4: Any other offset, including one not aligned to 16 bytes, reads 0, and a write to it changes no register.
- R5: With `hw_en` at 0, no request is accepted.
- R6: With `hw_en` 1 and software enable 1, every kind code 0 to 8 is accepted. The codes are 0 fixed, 1 lowest priority, 2 external, 3 SMI, 4 NMI, 5 INIT, 6 startup, 7 remote read, 8 local pin.
- R7: With `hw_en` 1 and software enable 0, kinds 3 to 8 are accepted and kinds 0 to 2 are rejected. Codes 9 to 15 are never accepted.
- R8: While software enable is 0, every source mask reads 1 and `lvt_mask` is all ones. The stored masks become 1, and a write carrying mask 0 leaves the mask at 1. After software enable returns to 1, the masks stay 1 until each entry is rewritten.
- R9: `hold_pending` is 1 exactly when software enable is 0.
- R10: `req_accept` and `req_reject` respond in the same cycle as `req_valid`. Reject is raised when and only when a valid request is not accepted, and neither is raised without `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_en | input | 1 | Hardware enable of the controller |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req_valid | input | 1 | Interrupt request present |
| req_kind | input | 4 | Request kind code |
| req_accept | output | 1 | Request accepted this cycle |
| req_reject | output | 1 | Request refused this cycle |
| hold_pending | output | 1 | Pending state must be frozen |
| lvt_mask | output | 6 | Effective mask of each source entry |

## Verification
The bench sweeps every kind code against all four enable combinations. A gate that confused the legacy and system classes, or that let the hardware disable be overridden, would show a wrong accept or reject for one specific code. The bench clears software enable and then writes mask 0 into entries. It checks that the mask still reads 1 and stays 1 after re-enable, which catches a design that only ORs the disable into the read path. Writes to misaligned offsets and to offsets just past the table are followed by readback of the neighbouring entries. This exposes decoders that ignore the low address bits or run past the last entry.

// File: rtl/igate_pkg.sv
package igate_pkg;

  typedef enum logic [3:0] {
    KIND_FIXED   = 4'd0,
    KIND_LOWPRI  = 4'd1,
    KIND_EXTINT  = 4'd2,
    KIND_SMI     = 4'd3,
    KIND_NMI     = 4'd4,
    KIND_INIT    = 4'd5,
    KIND_STARTUP = 4'd6,
    KIND_RMTRD   = 4'd7,
    KIND_LPIN    = 4'd8
  } req_kind_e;

  localparam logic [31:0] ENTRY_RESET = 32'h0001_0000;
  localparam logic [31:0] SVR_RESET   = 32'h0000_00FF;

  // Bit positions inside a source entry
  localparam int ENT_MASK_BIT = 16;
  localparam int ENT_TRIG_BIT = 15;
  localparam int SVR_SWEN_BIT = 8;

  // Ordinary vectored kinds, refused when software enable is low
  function automatic logic kind_is_vectored(input logic [3:0] k);
    return (k == KIND_FIXED) || (k == KIND_LOWPRI) || (k == KIND_EXTINT);
  endfunction

  // System-class kinds, still taken when software enable is low
  function automatic logic kind_is_system(input logic [3:0] k);
    return (k >= KIND_SMI) && (k <= KIND_LPIN);
  endfunction

endpackage

// File: rtl/igate_svr_reg.sv
module igate_svr_reg
  import igate_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFFSET = 12'h0F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rd_word,
  output logic              sw_en
);

  localparam int KEEP_W = SVR_SWEN_BIT + 1;

  logic              hit;
  logic              load;
  logic [KEEP_W-1:0] svr_q;
  logic [KEEP_W-1:0] svr_d;

  assign hit  = (addr == OFFSET);
  assign load = hit && wr_en;

  always_comb begin
    svr_d = svr_q;
    if (load) begin
      svr_d = wdata[KEEP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svr_q <= SVR_RESET[KEEP_W-1:0];
    end else begin
      svr_q <= svr_d;
    end
  end

  assign sw_en   = svr_q[SVR_SWEN_BIT];
  assign rd_word = hit ? {{(32-KEEP_W){1'b0}}, svr_q} : 32'd0;

  AST_SVR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == OFFSET)) |=> $stable(svr_q)); // R3

endmodule

// File: rtl/igate_src_entry.sv
module igate_src_entry
  import igate_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFFSET = 12'h320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              sw_en,
  output logic [31:0]       rd_word,
  output logic              mask_eff
);

  logic       hit;
  logic       load;
  logic [7:0] vec_q, vec_d;
  logic [2:0] kind_q, kind_d;
  logic       trig_q, trig_d;
  logic       mask_q, mask_d;

  assign hit  = (addr == OFFSET);
  assign load = hit && wr_en;

  always_comb begin
    vec_d  = vec_q;
    kind_d = kind_q;
    trig_d = trig_q;
    mask_d = mask_q | ~sw_en;
    if (load) begin
      vec_d  = wdata[7:0];
      kind_d = wdata[10:8];
      trig_d = wdata[ENT_TRIG_BIT];
      mask_d = wdata[ENT_MASK_BIT] | ~sw_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= ENTRY_RESET[7:0];
      kind_q <= ENTRY_RESET[10:8];
      trig_q <= ENTRY_RESET[ENT_TRIG_BIT];
      mask_q <= ENTRY_RESET[ENT_MASK_BIT];
    end else begin
      vec_q  <= vec_d;
      kind_q <= kind_d;
      trig_q <= trig_d;
      mask_q <= mask_d;
    end
  end

  assign mask_eff = mask_q | ~sw_en;
  assign rd_word  = hit ? {15'd0, mask_eff, trig_q, 4'd0, kind_q, vec_q} : 32'd0;

  AST_MASK_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> mask_q); // R8

endmodule

// File: rtl/igate_accept.sv
module igate_accept
  import igate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_en,
  input  logic       sw_en,
  input  logic       req_valid,
  input  logic [3:0] req_kind,
  output logic       req_accept,
  output logic       req_reject,
  output logic       hold_pending
);

  logic kind_ok;

  always_comb begin
    kind_ok = 1'b0;
    if (hw_en) begin
      if (sw_en) begin
        kind_ok = kind_is_vectored(req_kind) || kind_is_system(req_kind);
      end else begin
        kind_ok = kind_is_system(req_kind);
      end
    end
  end

  assign req_accept   = req_valid && kind_ok;
  assign req_reject   = req_valid && !kind_ok;
  assign hold_pending = ~sw_en;

  AST_HW_OFF_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_en |-> !req_accept); // R5
  AST_VECTORED_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_en && req_valid && req_kind <= 4'd2) |-> req_reject); // R7
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({req_accept, req_reject}) == {1'b0, req_valid}); // R10

endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
  import igate_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_SRC = 6,
  parameter logic [ADDR_W-1:0] SRC_BASE   = 12'h320,
  parameter logic [ADDR_W-1:0] SVR_OFFSET = 12'h0F0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hw_en,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               req_valid,
  input  logic [3:0]         req_kind,
  output logic               req_accept,
  output logic               req_reject,
  output logic               hold_pending,
  output logic [NUM_SRC-1:0] lvt_mask
);

  localparam int STRIDE_SH = 4;

  logic        sw_en;
  logic [31:0] svr_word;
  logic [31:0] src_word [NUM_SRC];

  igate_svr_reg #(
    .ADDR_W (ADDR_W),
    .OFFSET (SVR_OFFSET)
  ) u_svr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rd_word (svr_word),
    .sw_en   (sw_en)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam logic [ADDR_W-1:0] OFF = SRC_BASE + (ADDR_W'(g) << STRIDE_SH);
    igate_src_entry #(
      .ADDR_W (ADDR_W),
      .OFFSET (OFF)
    ) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .sw_en    (sw_en),
      .rd_word  (src_word[g]),
      .mask_eff (lvt_mask[g])
    );
  end

  always_comb begin
    reg_rdata = svr_word;
    for (int i = 0; i < NUM_SRC; i++) begin
      reg_rdata = reg_rdata | src_word[i];
    end
  end

  igate_accept u_accept (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_en        (hw_en),
    .sw_en        (sw_en),
    .req_valid    (req_valid),
    .req_kind     (req_kind),
    .req_accept   (req_accept),
    .req_reject   (req_reject),
    .hold_pending (hold_pending)
  );

  AST_SW_OFF_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    hold_pending |-> (&lvt_mask)); // R8
  AST_HOLD_FOLLOWS_SVR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == SVR_OFFSET) |=> (hold_pending == !$past(reg_wdata[SVR_SWEN_BIT]))); // R9

endmodule

// File: tb/irq_accept_gate_test.sv
module irq_accept_gate_test;

  logic        clk;
  logic        rst_n;
  logic        hw_en;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        req_valid;
  logic [3:0]  req_kind;
  logic        req_accept;
  logic        req_reject;
  logic        hold_pending;
  logic [5:0]  lvt_mask;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] shadow [6];

  irq_accept_gate uut (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_kind(req_kind),
    .req_accept(req_accept), .req_reject(req_reject),
    .hold_pending(hold_pending), .lvt_mask(lvt_mask)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  function automatic logic [31:0] src_off(input int i);
    return 32'h320 + 32'(i) * 32'h10;
  endfunction

  initial begin
    rst_n = 1'b0; hw_en = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    req_valid = 1'b0; req_kind = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 6; i++) rd_check("R1 entry reset", src_off(i)[11:0], 32'h0001_0000);
    rd_check("R1 svr reset", 12'h0F0, 32'h0000_00FF);
    check("R1 mask reset", {26'd0, lvt_mask}, 32'h3F);
    check("R1 hold reset", {31'd0, hold_pending}, 32'd1);

    // R3 software enable on, other bits dropped
    wr(12'h0F0, 32'hFFFF_FE5A);
    rd_check("R3 svr keep bits", 12'h0F0, 32'h0000_005A);
    wr(12'h0F0, 32'h0000_01A5);
    rd_check("R3 svr swen", 12'h0F0, 32'h0000_01A5);
    check("R9 hold off", {31'd0, hold_pending}, 32'd0);

    // R2 entry fields and mask bit order
    for (int i = 0; i < 6; i++) begin
      logic [31:0] d;
      d = 32'hFFFE_7000 ^ (32'(i) * 32'h0000_8123) ^ ((i % 2 == 1) ? 32'h0001_0000 : 32'h0);
      shadow[i] = d & 32'h0001_87FF;
      wr(src_off(i)[11:0], d);
    end
    for (int i = 0; i < 6; i++) rd_check("R2 entry readback", src_off(i)[11:0], shadow[i]);
    begin
      logic [31:0] em;
      em = '0;
      for (int i = 0; i < 6; i++) em[i] = shadow[i][16];
      check("R2 mask order", {26'd0, lvt_mask}, em);
    end

    // R4 unmapped and misaligned offsets
    wr(12'h324, 32'hFFFF_FFFF);
    wr(12'h380, 32'hFFFF_FFFF);
    wr(12'h0F4, 32'h0000_0000);
    wr(12'h310, 32'hFFFF_FFFF);
    rd_check("R4 misaligned read", 12'h324, 32'h0);
    rd_check("R4 past table read", 12'h380, 32'h0);
    rd_check("R4 unmapped read", 12'h000, 32'h0);
    rd_check("R4 svr untouched", 12'h0F0, 32'h0000_01A5);
    for (int i = 0; i < 6; i++) rd_check("R4 entry untouched", src_off(i)[11:0], shadow[i]);

    // R8 software disable forces and pins masks
    wr(12'h0F0, 32'h0000_00FF);
    check("R9 hold on", {31'd0, hold_pending}, 32'd1);
    check("R8 masks forced", {26'd0, lvt_mask}, 32'h3F);
    wr(12'h330, 32'h0000_0042);
    rd_check("R8 clear ignored", 12'h330, 32'h0001_0042);
    wr(12'h0F0, 32'h0000_01FF);
    check("R8 masks stay after reenable", {26'd0, lvt_mask}, 32'h3F);
    rd_check("R8 entry still masked", 12'h320, shadow[0] | 32'h0001_0000);
    wr(12'h320, 32'h0000_0011);
    rd_check("R8 clear after reenable", 12'h320, 32'h0000_0011);
    check("R8 mask bit0 cleared", {26'd0, lvt_mask}, 32'h3E);

    // R5 R6 R7 R9 R10 acceptance sweep
    for (int hw = 0; hw < 2; hw++) begin
      for (int sw = 0; sw < 2; sw++) begin
        wr(12'h0F0, (sw == 1) ? 32'h0000_01FF : 32'h0000_00FF);
        @(negedge clk);
        hw_en = (hw == 1);
        check("R9 hold vs swen", {31'd0, hold_pending}, (sw == 1) ? 32'd0 : 32'd1);
        for (int k = 0; k < 16; k++) begin
          logic exp_acc;
          exp_acc = (hw == 1) && (k <= 8) && ((sw == 1) || (k >= 3));
          @(negedge clk);
          req_kind = 4'(k);
          req_valid = 1'b0;
          #1;
          check("R10 idle no answer", {30'd0, req_accept, req_reject}, 32'd0);
          req_valid = 1'b1;
          #1;
          if (hw == 0) check("R5 accept", {31'd0, req_accept}, {31'd0, exp_acc});
          else if (sw == 1) check("R6 accept", {31'd0, req_accept}, {31'd0, exp_acc});
          else check("R7 accept", {31'd0, req_accept}, {31'd0, exp_acc});
          check("R10 reject", {31'd0, req_reject}, {31'd0, !exp_acc});
        end
        req_valid = 1'b0;
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule